// File: doc/BRIEF.md
# Dual-Mode Host Command Front End

This block sits between a host processor and a four-channel playback engine. A static strap picks one of two host interfaces that share the same eight data pins. With the strap low, the pins form a parallel byte bus: the host writes a command byte with a write strobe and reads per-channel flags with a read strobe. With the strap high, the pins are reused as a serial link: one pin carries the serial clock, one carries command bits in, one carries channel status out, one selects which flag set appears on a 4-bit status port, and the low four pins become that port.

All host pins are brought into one fast system clock domain through two-flop synchronizers. The block then finds strobe and serial-clock edges from the synchronized values. Each completed command byte is presented as a one-cycle valid pulse with the byte beside it. The block also drives the pin values and per-pin output enables for the shared pins. It does not decode commands.

Top module: `host_cmd_if`

## Requirements
- R1: With `mode_serial` low, `pin_oe` is either all zeros or all ones. With it high, `pin_oe[3:0]` is 4'hF, and `pin_oe[7:6]` and `pin_oe[4]` are 0.
- R2: While chip select (`cs_n`) is high, the read and write strobes have no effect: no `cmd_valid` pulse occurs and `pin_oe` stays 0 in parallel mode.
- R3: In parallel mode, each fall of the write strobe with chip select low gives exactly one `cmd_valid` pulse, and `cmd_byte` equals the value on `pin_in[7:0]`.
- R4: In parallel mode, with chip select and read low and write high, all eight pins are driven. `pin_out[7:4]` carries the busy flags of channels 4..1 (bit 4 = channel 1), and `pin_out[3:0]` carries the next-command-request flags of channels 4..1 (bit 0 = channel 1). A low write strobe removes the drive.
- R5: In serial mode, if the serial clock (`pin_in[6]`) is low when chip select falls, the data line is sampled on rising serial-clock edges. If it is high at that moment, the data line is sampled on falling edges.
- R6: Serial bytes arrive MSB first on `pin_in[7]`. After the eighth sampling edge, one `cmd_valid` pulse occurs with the assembled byte.
- R7: A rise of chip select in the middle of a serial byte discards the bits already received. The next transaction starts again from its first bit.
- R8: In serial mode, with chip select and read low, `pin_oe[5]` is 1 and `pin_out[5]` shows a status bit. Before the first sampling edge it shows the busy flag of channel 1, and each sampling edge moves it to the next channel, through channel 4. After that it shows 0. The flags are captured when chip select falls, so later changes to them do not alter the bits shifted out.
- R9: In serial mode, `pin_out[3:0]` shows the next-command-request flags when `pin_in[4]` is low and the busy flags when it is high, with bit i = channel i+1.
- R10: During and right after reset, `cmd_valid` is 0 and `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_serial | input | 1 | Interface strap: 1 = serial, 0 = parallel |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| pin_in | input | 8 | Input values of the shared data pins |
| ch_busy | input | 4 | Busy flags, bit i = channel i+1 |
| ch_ncr | input | 4 | Next-command-request flags, bit i = channel i+1 |
| pin_out | output | 8 | Values driven on the shared pins |
| pin_oe | output | 8 | Per-pin output enable |
| cmd_valid | output | 1 | One-cycle pulse per received command byte |
| cmd_byte | output | 8 | Received command byte, valid with `cmd_valid` |

## Verification
In serial mode, a command byte can be shifted in while channel status is shifted out, and both use the same sampling edge. The bench provokes this by holding read low through a serial write. It then changes the live busy flags after chip select falls. It judges the received byte through the `cmd_valid` pulse and each status bit on `pin_out[5]` just before each edge, and both must match at once. In parallel mode, the write and read strobes can be low together. The bench checks that the write is captured and that the drive is withdrawn.

// File: rtl/host_cmd_if.sv
module host_cmd_if (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_serial,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic [7:0] pin_in,
  input  logic [3:0] ch_busy,
  input  logic [3:0] ch_ncr,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte
);

  logic       cs_m, cs_s, cs_d;
  logic       wr_m, wr_s, rd_m, rd_s;
  logic [7:0] pin_m, pin_s;
  logic       sck_d, wr_d;
  logic       edge_pol;
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic [3:0] st_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_m <= 1'b1; cs_s <= 1'b1; cs_d <= 1'b1;
      wr_m <= 1'b1; wr_s <= 1'b1;
      rd_m <= 1'b1; rd_s <= 1'b1;
      pin_m <= '0; pin_s <= '0;
    end else begin
      cs_m <= cs_n;   cs_s <= cs_m;  cs_d <= cs_s;
      wr_m <= wr_n;   wr_s <= wr_m;
      rd_m <= rd_n;   rd_s <= rd_m;
      pin_m <= pin_in; pin_s <= pin_m;
    end

  wire sel_on   = !cs_s;
  wire cs_fall  = !cs_s && cs_d;
  wire sck      = pin_s[6];
  wire sdi      = pin_s[7];
  wire sck_rise = sck && !sck_d;
  wire sck_fall = !sck && sck_d;
  wire act_edge = mode_serial && sel_on && !cs_fall && (edge_pol ? sck_fall : sck_rise);
  wire wr_act   = !mode_serial && sel_on && !wr_s;
  wire rd_act   = sel_on && !rd_s;
  wire wr_go    = wr_act && !wr_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d <= 1'b0; wr_d <= 1'b0;
      edge_pol <= 1'b0; bit_cnt <= '0; sh_in <= '0; st_sh <= '0;
      cmd_valid <= 1'b0; cmd_byte <= '0;
    end else begin
      sck_d <= sck;
      wr_d  <= wr_act;
      cmd_valid <= 1'b0;
      if (!sel_on || !mode_serial) begin
        bit_cnt <= '0;
      end else if (cs_fall) begin
        edge_pol <= sck;
        bit_cnt  <= '0;
        st_sh    <= {ch_busy[0], ch_busy[1], ch_busy[2], ch_busy[3]};
      end else if (act_edge) begin
        sh_in   <= {sh_in[5:0], sdi};
        st_sh   <= {st_sh[2:0], 1'b0};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          cmd_valid <= 1'b1;
          cmd_byte  <= {sh_in, sdi};
        end
      end
      if (wr_go) begin
        cmd_valid <= 1'b1;
        cmd_byte  <= pin_s;
      end
    end

  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    if (mode_serial) begin
      pin_out[3:0] = pin_s[4] ? ch_busy : ch_ncr;
      pin_oe[3:0]  = 4'hF;
      pin_out[5]   = st_sh[3];
      pin_oe[5]    = rd_act;
    end else if (rd_act && !wr_act && wr_s) begin
      pin_out = {ch_busy, ch_ncr};
      pin_oe  = 8'hFF;
    end
  end

  assert_oe_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_serial |-> (pin_oe[3:0] == 4'hF && pin_oe[7:6] == 2'b00 && !pin_oe[4]));

  assert_par_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_serial |-> (pin_oe == 8'h00 || pin_oe == 8'hFF));

  assert_cs_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !cmd_valid);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_abort_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == 3'd0));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_serial && sel_on && !cs_fall && !act_edge) |=> $stable(st_sh));

endmodule

// File: tb/tb_host_cmd_if.sv
module tb_host_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_serial = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] pin_in = '0;
  logic [3:0] ch_busy = '0, ch_ncr = '0;
  logic [7:0] pin_out, pin_oe, cmd_byte;
  logic       cmd_valid;

  int n_chk = 0, n_bad = 0, n_pulse = 0;
  logic [7:0] last_byte = '0;

  host_cmd_if dut (.clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .cs_n(cs_n),
    .wr_n(wr_n), .rd_n(rd_n), .pin_in(pin_in), .ch_busy(ch_busy), .ch_ncr(ch_ncr),
    .pin_out(pin_out), .pin_oe(pin_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte));

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && cmd_valid) begin
    n_pulse <= n_pulse + 1;
    last_byte <= cmd_byte;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cmd_valid == 1'b0, "R10", cmd_valid, 0);
    chk(pin_oe == 8'h00, "R10", pin_oe, 0);
    rst_n = 1'b1; wt(4);
    chk(cmd_valid == 1'b0 && n_pulse == 0, "R10", n_pulse, 0);
    chk(pin_oe == 8'h00, "R10", pin_oe, 0);
  endtask

  task automatic par_write(input logic [7:0] b);
    int p0;
    p0 = n_pulse;
    pin_in = b; cs_n = 1'b0; wt(4);
    wr_n = 1'b0; wt(8);
    wr_n = 1'b1; wt(2); cs_n = 1'b1; wt(4);
    chk(n_pulse == p0 + 1, "R3", n_pulse - p0, 1);
    chk(last_byte == b, "R3", last_byte, b);
  endtask

  task automatic t_par_read;
    ch_busy = 4'b0110; ch_ncr = 4'b1001;
    cs_n = 1'b0; rd_n = 1'b0; wt(5);
    chk(pin_oe == 8'hFF, "R4", pin_oe, 8'hFF);
    chk(pin_out == 8'h69, "R4", pin_out, 8'h69);
    ch_busy = 4'b0001; wt(1);
    chk(pin_out[7:4] == 4'b0001, "R4", pin_out[7:4], 1);
    wr_n = 1'b0; pin_in = 8'h3C; wt(5);
    chk(pin_oe == 8'h00, "R4", pin_oe, 0);
    wr_n = 1'b1; rd_n = 1'b1; wt(2); cs_n = 1'b1; wt(4);
    chk(last_byte == 8'h3C, "R3", last_byte, 8'h3C);
    chk(pin_oe == 8'h00, "R1", pin_oe, 0);
  endtask

  task automatic t_cs_ignore;
    int p0;
    p0 = n_pulse;
    cs_n = 1'b1; pin_in = 8'hEE; wr_n = 1'b0; rd_n = 1'b0; wt(8);
    chk(pin_oe == 8'h00, "R2", pin_oe, 0);
    wr_n = 1'b1; wt(6);
    chk(n_pulse == p0, "R2", n_pulse - p0, 0);
    rd_n = 1'b1; wt(2);
  endtask

  task automatic ser_xfer(input logic [7:0] b, input bit pol, input int nbits,
                          input bit rd, input logic [3:0] snap, input bit scramble);
    pin_in[6] = pol; wt(4);
    cs_n = 1'b0; rd_n = !rd; wt(6);
    if (scramble) ch_busy = ~ch_busy;
    for (int i = 0; i < nbits; i++) begin
      pin_in[7] = b[7 - i]; wt(4);
      if (rd) begin
        chk(pin_oe[5] == 1'b1, "R8", pin_oe[5], 1);
        chk(pin_out[5] == ((i < 4) ? snap[i] : 1'b0), "R8", pin_out[5], (i < 4) ? snap[i] : 0);
      end
      pin_in[6] = !pol; wt(4);
      pin_in[7] = !b[7 - i]; wt(4);
      pin_in[6] = pol; wt(4);
    end
    cs_n = 1'b1; rd_n = 1'b1; wt(6);
  endtask

  task automatic t_serial(input logic [7:0] b, input bit pol, input string req);
    int p0;
    p0 = n_pulse;
    ser_xfer(b, pol, 8, 1'b0, 4'h0, 1'b0);
    chk(n_pulse == p0 + 1, req, n_pulse - p0, 1);
    chk(last_byte == b, req, last_byte, b);
  endtask

  task automatic t_abort;
    int p0;
    p0 = n_pulse;
    ser_xfer(8'hFF, 1'b0, 5, 1'b0, 4'h0, 1'b0);
    chk(n_pulse == p0, "R7", n_pulse - p0, 0);
    ser_xfer(8'h12, 1'b0, 8, 1'b0, 4'h0, 1'b0);
    chk(n_pulse == p0 + 1, "R7", n_pulse - p0, 1);
    chk(last_byte == 8'h12, "R7", last_byte, 8'h12);
  endtask

  task automatic t_duplex;
    int p0;
    p0 = n_pulse;
    ch_busy = 4'b1101;
    ser_xfer(8'h5A, 1'b1, 8, 1'b1, 4'b1101, 1'b1);
    chk(n_pulse == p0 + 1, "R6", n_pulse - p0, 1);
    chk(last_byte == 8'h5A, "R6", last_byte, 8'h5A);
    chk(pin_oe[5] == 1'b0, "R8", pin_oe[5], 0);
  endtask

  task automatic t_status_port;
    ch_busy = 4'b1010; ch_ncr = 4'b0011;
    pin_in[4] = 1'b0; wt(4);
    chk(pin_oe[3:0] == 4'hF && pin_oe[7:6] == 2'b00, "R1", pin_oe, 8'h0F);
    chk(pin_out[3:0] == 4'b0011, "R9", pin_out[3:0], 3);
    pin_in[4] = 1'b1; wt(4);
    chk(pin_out[3:0] == 4'b1010, "R9", pin_out[3:0], 4'hA);
    pin_in[4] = 1'b0; wt(2);
  endtask

  initial begin
    fork
      begin
        wt(2);
        t_reset;
        par_write(8'hA5);
        par_write(8'h00);
        t_par_read;
        t_cs_ignore;
        mode_serial = 1'b1; pin_in = '0; wt(4);
        t_status_port;
        t_serial(8'hC3, 1'b0, "R5");
        t_serial(8'h96, 1'b1, "R5");
        t_serial(8'h81, 1'b0, "R6");
        t_abort;
        t_duplex;
      end
      begin
        wt(50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule